// File: doc/BRIEF.md
# BCD Calendar Counter with Century

This block keeps wall-clock time and calendar date as packed-BCD bytes. A base-rate tick input feeds a prescaler. Each time the prescaler completes, the seconds field advances and carries ripple through minutes, hours, date, month and year in the same clock cycle. A separate century byte and a day-of-week counter ride along. Every field is a register driven straight onto an output, and all fields change on the same clock edge. Any read of the outputs in a single cycle is therefore a coherent snapshot.

A register-access path commits a complete new time with a one-cycle load strobe. The strobe writes every field together and clears the prescaler, so the first second after a load is a full second long. The hour byte carries its own format bit, which selects between a 24-hour count and a 12-hour count with an afternoon flag.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After synchronous reset, seconds, minutes, hours, date, month, year and day of week read 00h, century reads 20h, and the prescaler is cleared.
- R2: Seconds advance once for every TICK_DIV cycles with `tick_i` high. When neither `tick_i` nor `load_i` is high, every field holds its value.
- R3: Seconds and minutes count BCD 00 to 59. Each passes from 59 to 00 and carries into the next field.
- R4: With hour bit 7 clear (24-hour format), hour bits 5:0 count BCD 00 to 23. The step from 23 to 00 advances the date.
- R5: With hour bit 7 set (12-hour format), bits 4:0 count BCD 01 to 12 and bit 5 is the afternoon flag. Going from 11 to 12 toggles bit 5. Going from 12 to 01 leaves bit 5 unchanged. The step from 11 with bit 5 set advances the date. Bit 7 is preserved.
- R6: Date counts BCD 01 up to the length of the current month and then returns to 01, advancing the month. Months 04, 06, 09 and 11 have 30 days, February has 28 or 29 days, and all others have 31. A date of 00 advances to 01.
- R7: February has 29 days when the BCD year, read as a decimal number, is a multiple of 4 (year 00 included).
- R8: Month counts BCD 01 to 12 and carries into the year when it wraps. Year counts BCD 00 to 99. A month of 00 advances to 01.
- R9: Day of week is a 3-bit value on `dow_o`. It advances on each date advance, and 6 is followed by 0.
- R10: When the year wraps from 99 to 00, the century becomes 20h.
- R11: A high `load_i` writes all eight load inputs into the fields on that clock edge and restarts the prescaler. It takes priority over `tick_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Base-rate tick, one cycle per pulse |
| load_i | input | 1 | Commit strobe for a full time load |
| ld_sec_i | input | 8 | Seconds to load (BCD) |
| ld_min_i | input | 8 | Minutes to load (BCD) |
| ld_hour_i | input | 8 | Hour byte to load, including format and afternoon bits |
| ld_date_i | input | 8 | Date to load (BCD) |
| ld_month_i | input | 8 | Month to load (BCD) |
| ld_year_i | input | 8 | Year to load (BCD) |
| ld_dow_i | input | 3 | Day of week to load |
| ld_cent_i | input | 8 | Century to load (BCD 19 or 20) |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour byte |
| date_o | output | 8 | Date |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |
| dow_o | output | 3 | Day of week |
| cent_o | output | 8 | Century |

## Verification
The bench targets the places where a full carry chain fires in one cycle. These are New Year's Eve of year 99, with its century step and day-of-week wrap, and the month ends at 30, 31, 28 and 29 days, including year 00 as a leap year. A wrong leap rule would leave February 29 missing or add it in a common year. A broken 30-day table would produce an April 31. In 12-hour format the bench crosses 11 to 12 in both halves of the day and 12 to 01. A swapped flag toggle would flip afternoon at the wrong step or advance the date at noon. The bench also applies a load in the same cycle as a tick on a partly filled prescaler. A design that lets the tick win, or that does not clear the prescaler, would advance the seconds early.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [7:0] CENT_RESET = 8'h20;

  // Increment a packed BCD byte (valid input assumed; low digit 9 carries).
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
    else                r = v + 8'd1;
    return r;
  endfunction

  // Leap test on a BCD year: decimal value divisible by four.
  function automatic logic bcd_leap(input logic [7:0] yr);
    logic lp;
    if (yr[4]) lp = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       lp = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return lp;
  endfunction

  // Last date of a month, as BCD.
  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] d;
    case (mon)
      8'h02:                      d = bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic load_i,
  output logic sec_pulse_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign sec_pulse_o = tick_i && !load_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || load_i)     cnt_q <= '0;
    else if (tick_i)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == '0));  // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=> $stable(cnt_q));  // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST && tick_i && !load_i) |=> (cnt_q == '0));  // R2

endmodule

// File: rtl/bcd_mod_cnt.sv
module bcd_mod_cnt #(
  parameter logic [7:0] LO = 8'h00,
  parameter logic [7:0] HI = 8'h59
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc_i,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  output logic [7:0] q_o,
  output logic       wrap_o
);
  import rtc_pkg::*;

  assign wrap_o = inc_i && !load_i && (q_o >= HI);

  always_ff @(posedge clk) begin
    if (rst)         q_o <= 8'h00;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= (q_o >= HI) ? LO : bcd_inc8(q_o);
  end

  AST_WRAP_TO_LO: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i && q_o >= HI) |=> (q_o == LO));  // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !load_i) |=> $stable(q_o));  // R2

endmodule

// File: rtl/rtc_hour_cnt.sv
module rtc_hour_cnt (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc_i,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  output logic [7:0] q_o,
  output logic       day_o
);
  import rtc_pkg::*;

  logic       fmt12, pm;
  logic [7:0] inc24, inc12, nxt;
  logic       day_raw;

  assign fmt12 = q_o[7];
  assign pm    = q_o[5];
  assign inc24 = bcd_inc8({2'b00, q_o[5:0]});
  assign inc12 = bcd_inc8({3'b000, q_o[4:0]});

  always_comb begin
    nxt     = q_o;
    day_raw = 1'b0;
    if (!fmt12) begin
      if (q_o[5:0] >= 6'h23) begin
        nxt     = 8'h00;
        day_raw = 1'b1;
      end else begin
        nxt = inc24 & 8'h3F;
      end
    end else begin
      if (q_o[4:0] == 5'h11) begin
        nxt     = {1'b1, 1'b0, ~pm, 5'h12};
        day_raw = pm;
      end else if (q_o[4:0] >= 5'h12 || q_o[4:0] == 5'h00) begin
        nxt = {1'b1, 1'b0, pm, 5'h01};
      end else begin
        nxt = 8'h80 | {2'b00, pm, 5'b00000} | (inc12 & 8'h1F);
      end
    end
  end

  assign day_o = inc_i && !load_i && day_raw;

  always_ff @(posedge clk) begin
    if (rst)         q_o <= 8'h00;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= nxt;
  end

  AST_MIDNIGHT_24: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i && !q_o[7] && q_o[5:0] == 6'h23) |=> (q_o == 8'h00));  // R4
  AST_PM_FLIP: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i && q_o[7] && q_o[4:0] == 5'h11) |=> (q_o[5] != $past(q_o[5])));  // R5
  AST_FORMAT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !load_i) |=> (q_o[7] == $past(q_o[7])));  // R5

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar #(
  parameter int TICK_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_date_i,
  input  logic [7:0] ld_month_i,
  input  logic [7:0] ld_year_i,
  input  logic [2:0] ld_dow_i,
  input  logic [7:0] ld_cent_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [2:0] dow_o,
  output logic [7:0] cent_o
);
  import rtc_pkg::*;

  logic       sec_pulse, sec_wrap, min_wrap, day_inc, mon_wrap, yr_wrap;
  logic       date_wrap;
  logic [7:0] last_day, date_nxt;

  rtc_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i), .sec_pulse_o(sec_pulse));

  bcd_mod_cnt #(.LO(8'h00), .HI(8'h59)) u_sec (
    .clk(clk), .rst(rst), .inc_i(sec_pulse), .load_i(load_i),
    .load_val_i(ld_sec_i), .q_o(sec_o), .wrap_o(sec_wrap));

  bcd_mod_cnt #(.LO(8'h00), .HI(8'h59)) u_min (
    .clk(clk), .rst(rst), .inc_i(sec_wrap), .load_i(load_i),
    .load_val_i(ld_min_i), .q_o(min_o), .wrap_o(min_wrap));

  rtc_hour_cnt u_hour (
    .clk(clk), .rst(rst), .inc_i(min_wrap), .load_i(load_i),
    .load_val_i(ld_hour_i), .q_o(hour_o), .day_o(day_inc));

  always_comb begin
    last_day  = month_last(month_o, year_o);
    date_wrap = day_inc && (date_o >= last_day);
    date_nxt  = (date_o >= last_day) ? 8'h01 : bcd_inc8(date_o);
  end

  bcd_mod_cnt #(.LO(8'h01), .HI(8'h12)) u_month (
    .clk(clk), .rst(rst), .inc_i(date_wrap), .load_i(load_i),
    .load_val_i(ld_month_i), .q_o(month_o), .wrap_o(mon_wrap));

  bcd_mod_cnt #(.LO(8'h00), .HI(8'h99)) u_year (
    .clk(clk), .rst(rst), .inc_i(mon_wrap), .load_i(load_i),
    .load_val_i(ld_year_i), .q_o(year_o), .wrap_o(yr_wrap));

  always_ff @(posedge clk) begin
    if (rst) begin
      date_o <= 8'h00;
      dow_o  <= 3'd0;
      cent_o <= CENT_RESET;
    end else if (load_i) begin
      date_o <= ld_date_i;
      dow_o  <= ld_dow_i;
      cent_o <= ld_cent_i;
    end else begin
      if (day_inc) begin
        date_o <= date_nxt;
        dow_o  <= (dow_o >= 3'd6) ? 3'd0 : dow_o + 3'd1;
      end
      if (yr_wrap) cent_o <= CENT_RESET;
    end
  end

  AST_DATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (day_inc && !load_i) |=> (date_o != 8'h00));  // R6
  AST_LEAP_Y00: assert property (@(posedge clk) disable iff (rst)
    (day_inc && !load_i && month_o == 8'h02 && date_o == 8'h28 && year_o == 8'h00)
    |=> (date_o == 8'h29));  // R7
  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (rst)
    (day_inc && !load_i && dow_o == 3'd6) |=> (dow_o == 3'd0));  // R9
  AST_CENT_STEP: assert property (@(posedge clk) disable iff (rst)
    (yr_wrap && !load_i) |=> (cent_o == 8'h20 && year_o == 8'h00));  // R10
  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (sec_o == $past(ld_sec_i) && cent_o == $past(ld_cent_i)));  // R11

endmodule

// File: tb/rtc_bcd_calendar_bench.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_bench;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, load = 1'b0;
  logic [7:0] l_sec = 0, l_min = 0, l_hour = 0, l_date = 0, l_mon = 0, l_yr = 0, l_cent = 0;
  logic [2:0] l_dow = 0;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o, cent_o;
  logic [2:0] dow_o;

  int checks = 0, errors = 0;
  bit armed = 0;

  always #10 clk = ~clk;

  rtc_bcd_calendar #(.TICK_DIV(DIV)) u_rtc_bcd_calendar (
    .clk(clk), .rst(rst), .tick_i(tick), .load_i(load),
    .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hour), .ld_date_i(l_date),
    .ld_month_i(l_mon), .ld_year_i(l_yr), .ld_dow_i(l_dow), .ld_cent_i(l_cent),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .date_o(date_o),
    .month_o(month_o), .year_o(year_o), .dow_o(dow_o), .cent_o(cent_o));

  // Reference model in plain integers
  int m_sec, m_min, m_hr, m_date, m_mon, m_yr, m_dow, m_cen, m_pre;
  bit m_f12, m_pm;

  function automatic int bcd(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int bin(int b); return ((b >> 4) & 15) * 10 + (b & 15); endfunction

  function automatic int days_in(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_day();
    m_dow = (m_dow >= 6) ? 0 : m_dow + 1;
    if (m_date >= days_in(m_mon, m_yr)) begin
      m_date = 1;
      if (m_mon >= 12) begin
        m_mon = 1;
        if (m_yr >= 99) begin m_yr = 0; m_cen = 20; end
        else m_yr++;
      end else m_mon++;
    end else m_date++;
  endtask

  task automatic model_second();
    bit day = 0;
    if (m_sec < 59) begin m_sec++; return; end
    m_sec = 0;
    if (m_min < 59) begin m_min++; return; end
    m_min = 0;
    if (!m_f12) begin
      if (m_hr >= 23) begin m_hr = 0; day = 1; end else m_hr++;
    end else begin
      if (m_hr == 11) begin m_hr = 12; day = m_pm; m_pm = !m_pm; end
      else if (m_hr >= 12 || m_hr == 0) m_hr = 1;
      else m_hr++;
    end
    if (day) model_day();
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_date = 0; m_mon = 0; m_yr = 0;
      m_dow = 0; m_cen = 20; m_pre = 0; m_f12 = 0; m_pm = 0;
    end else if (load) begin
      m_sec = bin(l_sec); m_min = bin(l_min); m_date = bin(l_date);
      m_mon = bin(l_mon); m_yr = bin(l_yr); m_dow = l_dow; m_cen = bin(l_cent);
      m_f12 = l_hour[7]; m_pm = l_hour[5];
      m_hr = m_f12 ? bin(l_hour & 8'h1F) : bin(l_hour & 8'h3F);
      m_pre = 0;
    end else if (tick) begin
      if (m_pre == DIV - 1) begin m_pre = 0; model_second(); end
      else m_pre++;
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  function automatic int m_hour_byte();
    return m_f12 ? (8'h80 | (m_pm << 5) | bcd(m_hr)) : bcd(m_hr);
  endfunction

  always @(negedge clk) if (armed) begin
    chk("R3", "sec", sec_o, bcd(m_sec));
    chk("R3", "min", min_o, bcd(m_min));
    chk(m_f12 ? "R5" : "R4", "hour", hour_o, m_hour_byte());
    chk("R6", "date", date_o, bcd(m_date));
    chk("R8", "month", month_o, bcd(m_mon));
    chk("R8", "year", year_o, bcd(m_yr));
    chk("R9", "dow", dow_o, m_dow);
    chk("R10", "cent", cent_o, bcd(m_cen));
  end

  task automatic load_all(input logic [7:0] s, mi, h, d, mo, y, input logic [2:0] w,
                          input logic [7:0] c, input bit with_tick);
    @(negedge clk);
    l_sec = s; l_min = mi; l_hour = h; l_date = d; l_mon = mo; l_yr = y; l_dow = w; l_cent = c;
    load = 1'b1; tick = with_tick;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic run_random(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); tick = ($urandom % 4) != 0;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk); armed = 1;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "reset sec", sec_o, 8'h00);
    chk("R1", "reset hour", hour_o, 8'h00);
    chk("R1", "reset date", date_o, 8'h00);
    chk("R1", "reset cent", cent_o, 8'h20);
    rst = 1'b0;
    // R2 prescaler: DIV-1 ticks do nothing, the DIV-th advances, from 00h date/month go to 01
    ticks(DIV - 1);
    chk("R2", "no step yet", sec_o, 8'h00);
    ticks(1);
    chk("R2", "one second", sec_o, 8'h01);
    repeat (5) @(negedge clk);
    chk("R2", "idle hold", sec_o, 8'h01);
    ticks(DIV * 200);
    chk("R3", "minute carry", min_o, 8'h03);
    chk("R3", "seconds after 201", sec_o, 8'h21);
    // R10/R9/R8/R6 New Year 99 in 24-hour format
    load_all(8'h58, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 3'd6, 8'h19, 0);
    ticks(DIV * 2);
    chk("R4", "midnight", hour_o, 8'h00);
    chk("R6", "date wrap", date_o, 8'h01);
    chk("R8", "year wrap", year_o, 8'h00);
    chk("R9", "dow wrap", dow_o, 3'd0);
    chk("R10", "century", cent_o, 8'h20);
    // R5 12-hour format
    load_all(8'h59, 8'h59, 8'hB1, 8'h10, 8'h05, 8'h21, 3'd2, 8'h20, 0);
    ticks(DIV);
    chk("R5", "11PM to 12AM", hour_o, 8'h92);
    chk("R5", "date after midnight", date_o, 8'h11);
    load_all(8'h59, 8'h59, 8'h91, 8'h10, 8'h05, 8'h21, 3'd2, 8'h20, 0);
    ticks(DIV);
    chk("R5", "11AM to 12PM", hour_o, 8'hB2);
    chk("R5", "noon keeps date", date_o, 8'h10);
    load_all(8'h59, 8'h59, 8'hB2, 8'h10, 8'h05, 8'h21, 3'd2, 8'h20, 0);
    ticks(DIV);
    chk("R5", "12PM to 1PM", hour_o, 8'hA1);
    // R6/R7 month ends
    load_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 3'd1, 8'h20, 0);
    ticks(DIV);
    chk("R7", "leap 24 feb29", date_o, 8'h29);
    ticks(DIV * 86400 / 86400);
    load_all(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 3'd1, 8'h20, 0);
    ticks(DIV);
    chk("R7", "feb29 to mar", month_o, 8'h03);
    load_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 3'd1, 8'h20, 0);
    ticks(DIV);
    chk("R7", "common year", date_o, 8'h01);
    load_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 3'd1, 8'h20, 0);
    ticks(DIV);
    chk("R7", "year 00 leap", date_o, 8'h29);
    load_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h05, 3'd1, 8'h20, 0);
    ticks(DIV);
    chk("R6", "april 30 end", month_o, 8'h05);
    load_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h05, 3'd1, 8'h20, 0);
    ticks(DIV);
    chk("R6", "jan 31 exists", date_o, 8'h31);
    // R11 load beats tick and restarts prescaler
    ticks(2);
    load_all(8'h10, 8'h20, 8'h05, 8'h15, 8'h06, 8'h30, 3'd3, 8'h20, 1);
    chk("R11", "loaded sec", sec_o, 8'h10);
    chk("R11", "loaded dow", dow_o, 3'd3);
    ticks(DIV - 1);
    chk("R11", "prescaler restarted", sec_o, 8'h10);
    ticks(1);
    chk("R11", "first second", sec_o, 8'h11);
    // Random-rate runs across midnight and year end
    load_all(8'h00, 8'h58, 8'hB1, 8'h31, 8'h12, 8'h99, 3'd5, 8'h19, 0);
    run_random(6000);
    load_all(8'h00, 8'h45, 8'h23, 8'h28, 8'h02, 8'h00, 3'd0, 8'h20, 0);
    run_random(6000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule